// File: doc/BRIEF.md
# Two-Tier Rotating DMA Channel Arbiter

This block decides which of six DMA channels owns a shared 16-bit DMA bus for the next element transfer. A per-channel priority bit puts each channel in an upper or a lower group. Each group rotates fairly among its own members and keeps its own rotation pointer. The lower group is considered only when no upper-group channel is ready. A channel counts as ready when its request line is high, which the channel sequencer drives only while it has a sync event pending and transfers left. A channel whose enable bit is low is never chosen.

An auxiliary host requester ranks above both channel groups. The processor ranks below all of them and is reported as the bus owner whenever no grant is held. Each decision covers one element. The grant stays in place until the element-done strobe arrives, the bus is released on that edge, and the next decision is made on the edge after that.

Top module: `dma_two_tier_arb`

## Requirements
- R1: After reset no grant is held, `ch_gnt_o` is 0, `ch_idx_o` is 0, `cpu_gnt_o` is 1, and both rotation pointers sit at channel 0, so the first upper-group decision among all six channels picks channel 0.
- R2: When no channel is eligible and the host does not request, no grant is issued and `cpu_gnt_o` stays 1.
- R3: A channel whose `ch_en_i` bit is 0 is never granted, whatever its request and priority bits are.
- R4: A lower-group channel (`ch_hi_i` bit 0) is granted only when no enabled, requesting upper-group channel (`ch_hi_i` bit 1) exists at the decision edge.
- R5: Within a group, the grant goes to the first eligible channel at or after that group's pointer, in ascending order and wrapping from channel 5 to channel 0. The pointer then moves to the channel just after the one granted, wrapping after channel 5.
- R6: Each group has its own pointer, and a grant from one group leaves the other group's pointer unchanged.
- R7: While a grant is held and `elem_done_i` is low, `ch_gnt_o`, `ch_idx_o` and `host_gnt_o` do not change, even when requests, enables or priority bits change.
- R8: The grant is released on the rising edge at which `elem_done_i` is sampled high. The next grant is registered on the following edge, so there is exactly one idle cycle between two grants. `elem_done_i` has no effect while no grant is held.
- R9: A high `host_req_i` at a decision edge grants the host (`host_gnt_o` 1, `ch_gnt_o` 0) ahead of every channel. A host grant moves neither pointer.
- R10: `cpu_gnt_o` is 1 exactly when neither a channel grant nor a host grant is held.
- R11: `ch_gnt_o` is one-hot or zero, at most one of `ch_gnt_o` and `host_gnt_o` is non-zero, and `ch_idx_o` is the binary number of the granted channel (0 when no channel is granted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_req_i | input | 6 | Per-channel ready/request |
| ch_en_i | input | 6 | Per-channel enable |
| ch_hi_i | input | 6 | Per-channel group select, 1 = upper group |
| host_req_i | input | 1 | Auxiliary host request, ranks above all channels |
| elem_done_i | input | 1 | Strobe marking the end of the element in progress |
| ch_gnt_o | output | 6 | One-hot channel grant |
| ch_idx_o | output | 3 | Binary number of the granted channel |
| host_gnt_o | output | 1 | Host holds the bus |
| cpu_gnt_o | output | 1 | Processor holds the bus (no grant held) |

## Verification
Every output comes directly from a register. A decision made on the inputs present at one rising edge therefore shows up after that edge, and the bench reads it at the next falling edge. The release that follows a done strobe shows up one edge after the strobe is sampled. The bench drives each stimulus at a falling edge, waits one rising edge, and compares at the next falling edge. It then asserts done for one cycle and checks the idle cycle before it applies the next pattern. A reference model in the bench keeps its own pair of pointers and computes the expected grant for every request pattern under several enable and priority masks.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HOST = 2'd1,
        SRC_UPPER = 2'd2,
        SRC_LOWER = 2'd3
    } owner_e;

endpackage

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
    parameter int N = 6,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [N-1:0]  elig_i,
    input  logic [PW-1:0] ptr_i,
    output logic          found_o,
    output logic [PW-1:0] sel_o
);

    // Scan from the pointer upwards with wrap; the nearest hit wins,
    // so the loop runs from the farthest offset down to offset zero.
    always_comb begin
        found_o = 1'b0;
        sel_o   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int pos;
            pos = int'(ptr_i) + k;
            if (pos >= N) pos = pos - N;
            if (elig_i[pos]) begin
                found_o = 1'b1;
                sel_o   = PW'(pos);
            end
        end
    end

    // R5: the chosen channel is eligible
    a_r5_pick_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
        found_o |-> elig_i[sel_o]);

    // R2: nothing is found when no channel is eligible
    a_r2_none_found: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (elig_i == '0) |-> !found_o);

endmodule

// File: rtl/dma_two_tier_arb.sv
module dma_two_tier_arb
    import dma_arb_pkg::*;
#(
    parameter int N = 6,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [N-1:0]  ch_req_i,
    input  logic [N-1:0]  ch_en_i,
    input  logic [N-1:0]  ch_hi_i,
    input  logic          host_req_i,
    input  logic          elem_done_i,
    output logic [N-1:0]  ch_gnt_o,
    output logic [PW-1:0] ch_idx_o,
    output logic          host_gnt_o,
    output logic          cpu_gnt_o
);

    localparam int NGRP = 2;

    typedef struct packed {
        logic          busy;
        owner_e        owner;
        logic [N-1:0]  gnt;
        logic [PW-1:0] idx;
        logic [PW-1:0] ptr_up;
        logic [PW-1:0] ptr_lo;
    } arb_state_t;

    arb_state_t s_d, s_q;

    logic [N-1:0]  grp_elig  [NGRP];
    logic [PW-1:0] grp_ptr   [NGRP];
    logic          grp_found [NGRP];
    logic [PW-1:0] grp_sel   [NGRP];

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] v);
        return (int'(v) == N - 1) ? '0 : v + 1'b1;
    endfunction

    always_comb begin
        grp_elig[0] = ch_req_i & ch_en_i & ch_hi_i;
        grp_elig[1] = ch_req_i & ch_en_i & ~ch_hi_i;
        grp_ptr[0]  = s_q.ptr_up;
        grp_ptr[1]  = s_q.ptr_lo;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        dma_rr_pick #(.N(N)) u_pick (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .elig_i  (grp_elig[g]),
            .ptr_i   (grp_ptr[g]),
            .found_o (grp_found[g]),
            .sel_o   (grp_sel[g])
        );
    end

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (elem_done_i) begin
                s_d.busy  = 1'b0;
                s_d.owner = SRC_NONE;
                s_d.gnt   = '0;
                s_d.idx   = '0;
            end
        end else if (host_req_i) begin
            s_d.busy  = 1'b1;
            s_d.owner = SRC_HOST;
        end else if (grp_found[0]) begin
            s_d.busy   = 1'b1;
            s_d.owner  = SRC_UPPER;
            s_d.gnt    = N'(1) << grp_sel[0];
            s_d.idx    = grp_sel[0];
            s_d.ptr_up = step_ptr(grp_sel[0]);
        end else if (grp_found[1]) begin
            s_d.busy   = 1'b1;
            s_d.owner  = SRC_LOWER;
            s_d.gnt    = N'(1) << grp_sel[1];
            s_d.idx    = grp_sel[1];
            s_d.ptr_lo = step_ptr(grp_sel[1]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{busy: 1'b0, owner: SRC_NONE, gnt: '0, idx: '0,
                     ptr_up: '0, ptr_lo: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ch_gnt_o   = s_q.gnt;
    assign ch_idx_o   = s_q.idx;
    assign host_gnt_o = (s_q.owner == SRC_HOST);
    assign cpu_gnt_o  = !s_q.busy;

    // R11: at most one owner on the bus
    a_r11_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({host_gnt_o, ch_gnt_o}));

    // R7: grant frozen until the done strobe
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cpu_gnt_o && !elem_done_i) |=>
            ($stable(ch_gnt_o) && $stable(host_gnt_o) && $stable(ch_idx_o)));

    // R8: release on the edge that samples done
    a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cpu_gnt_o && elem_done_i) |=> (cpu_gnt_o && ch_gnt_o == '0));

    // R3: a fresh grant only goes to a channel that was enabled
    a_r3_enabled_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_gnt_o |=> ((ch_gnt_o & ~$past(ch_en_i)) == '0));

    // R4: lower group waits while an upper channel is ready
    a_r4_upper_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_gnt_o && !host_req_i && (ch_req_i & ch_en_i & ch_hi_i) != '0) |=>
            ((ch_gnt_o & ~$past(ch_hi_i)) == '0 && ch_gnt_o != '0));

    // R9: host wins a decision
    a_r9_host_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cpu_gnt_o && host_req_i) |=> (host_gnt_o && ch_gnt_o == '0));

    // R6: an upper grant leaves the lower pointer alone
    a_r6_split_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.owner == SRC_UPPER && $past(s_q.owner) == SRC_NONE) |-> $stable(s_q.ptr_lo));

    // R10: processor owns the bus exactly when nothing is granted
    a_r10_cpu_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_gnt_o == (ch_gnt_o == '0 && !host_gnt_o));

endmodule

// File: tb/dma_two_tier_arb_tb.sv
module dma_two_tier_arb_tb;

    localparam int N = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] req = '0, en = '0, hi = '0;
    logic       host = 1'b0, done = 1'b0;
    logic [5:0] gnt;
    logic [2:0] idx;
    logic       host_gnt, cpu_gnt;

    int checks = 0;
    int fails = 0;
    int ptr_u = 0;
    int ptr_l = 0;
    bit finished = 0;

    always #4ns clk = ~clk;

    dma_two_tier_arb #(.N(N)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ch_req_i(req), .ch_en_i(en),
        .ch_hi_i(hi), .host_req_i(host), .elem_done_i(done),
        .ch_gnt_o(gnt), .ch_idx_o(idx), .host_gnt_o(host_gnt),
        .cpu_gnt_o(cpu_gnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pick(input logic [5:0] e, input int p);
        for (int k = 0; k < N; k++) begin
            if (e[(p + k) % N]) return (p + k) % N;
        end
        return -1;
    endfunction

    task automatic idle_checks(input string tag);
        chk({tag, " gnt"}, int'(gnt), 0);
        chk({tag, " cpu"}, int'(cpu_gnt), 1);
        chk({tag, " host"}, int'(host_gnt), 0);
    endtask

    // Called just after a falling edge with the design idle.
    task automatic trial(input logic [5:0] r, input logic [5:0] e, input logic [5:0] h);
        int su, sl, exp_ch;
        req = r; en = e; hi = h;
        su = pick(r & e & h, ptr_u);
        sl = pick(r & e & ~h, ptr_l);
        exp_ch = (su >= 0) ? su : sl;
        @(posedge clk); @(negedge clk);
        if (exp_ch < 0) begin
            idle_checks("R2");
        end else begin
            chk("R3 R4 R5 R6 gnt", int'(gnt), 1 << exp_ch);
            chk("R11 idx", int'(idx), exp_ch);
            chk("R10 cpu", int'(cpu_gnt), 0);
            if (su >= 0) ptr_u = (su + 1) % N;
            else         ptr_l = (sl + 1) % N;
            done = 1'b1;
            @(posedge clk); @(negedge clk);
            done = 1'b0;
            idle_checks("R8 release");
            chk("R11 idx idle", int'(idx), 0);
        end
    endtask

    initial begin
        #(8ns * 150000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] hi_set [4];
        logic [5:0] en_set [3];
        logic [5:0] held;
        hi_set = '{6'b111111, 6'b000000, 6'b101010, 6'b000111};
        en_set = '{6'b111111, 6'b011011, 6'b110101};
        repeat (3) @(negedge clk);
        // R1: reset values
        idle_checks("R1 reset");
        chk("R1 idx", int'(idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: done while idle has no effect
        done = 1'b1;
        @(posedge clk); @(negedge clk);
        done = 1'b0;
        idle_checks("R8 idle done");
        // R1: first upper decision among all picks channel 0
        trial(6'b111111, 6'b111111, 6'b111111);
        chk("R1 first pick ptr", ptr_u, 1);

        // Sweep: request patterns x enable masks x group masks
        foreach (hi_set[i]) begin
            foreach (en_set[j]) begin
                for (int r = 0; r < 64; r++) trial(6'(r), en_set[j], hi_set[i]);
            end
        end

        // R7: grant frozen while inputs move
        req = 6'b001100; en = 6'b111111; hi = 6'b000000;
        @(posedge clk); @(negedge clk);
        held = gnt;
        chk("R7 got grant", int'(held != 0), 1);
        for (int c = 0; c < 5; c++) begin
            req = 6'(c * 13); en = 6'(~c); hi = 6'(c * 7); host = c[0];
            @(posedge clk); @(negedge clk);
            chk("R7 hold", int'(gnt), int'(held));
            chk("R7 host low", int'(host_gnt), 0);
        end
        host = 1'b0;
        ptr_l = (held == 6'b000100) ? 3 : 4;
        done = 1'b1;
        @(posedge clk); @(negedge clk);
        done = 1'b0;
        idle_checks("R8 after hold");

        // R9: host beats every channel and leaves pointers alone
        host = 1'b1; req = 6'b111111; en = 6'b111111; hi = 6'b110000;
        @(posedge clk); @(negedge clk);
        chk("R9 host gnt", int'(host_gnt), 1);
        chk("R9 ch gnt", int'(gnt), 0);
        chk("R10 cpu host", int'(cpu_gnt), 0);
        host = 1'b0;
        done = 1'b1;
        @(posedge clk); @(negedge clk);
        done = 1'b0;
        idle_checks("R9 host release");
        trial(6'b111111, 6'b111111, 6'b110000);
        trial(6'b001111, 6'b111111, 6'b110000);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule